// File: doc/BRIEF.md
# DTMF Steering and Output Latch

This block sits behind a tone-pair detector and decides when a detected pair becomes a registered digit. The detector supplies a "pair present" flag together with a 4-bit candidate code. In place of an external resistor-capacitor timing network, two digital guard timers judge duration. The first checks that the flag has stayed up long enough to count as a real digit. The second checks that it has stayed down long enough to count as a real pause between digits.

Both guard times are counted in ticks from an internal divider, one tick every `TICK_DIV` clocks, which is nominally one millisecond. Each guard time is loaded from its own input, so the two can be set independently. When a digit is accepted, its code goes into an output latch. A "digit valid" flag then rises a fixed number of settling cycles later, and it stays up until the pause has been confirmed. The latched code is presented behind an output enable. A disabled bus is modelled as a low drive flag with zero data.

Top module: `dtmf_steer`

## Requirements
- R1: A candidate is accepted only when the present flag stays high, with an unchanging code, for at least `guard_present` ticks. Shorter bursts leave both the latch and `digit_valid` untouched.
- R2: On acceptance the code is written into the latch. `digit_valid` rises exactly `SETTLE`+1 clock cycles after the latch changes, and the latch does not change while `digit_valid` is high.
- R3: After acceptance, `digit_valid` falls, and the block becomes ready for a new digit, only once the present flag has been low for `guard_absent` ticks.
- R4: Gaps in the present flag shorter than the absent guard are bridged. `digit_valid` stays high, and a different code arriving after such a gap is not registered.
- R5: The present and absent guard times are set independently. Either one may be longer than the other.
- R6: With `out_en` high, `bus_drive` is 1 and `bus_code` shows the latched code. With `out_en` low, `bus_drive` is 0 and `bus_code` is 0, which stands for high impedance.
- R7: While `inhibit_abcd` is high, candidates with codes 13, 14, 15 and 0 (letters A, B, C, D) are ignored, and the latch keeps the last accepted code. With `inhibit_abcd` low, those codes are accepted like any other.
- R8: A change of candidate code while the block is waiting out the present guard restarts the guard. The code that gets latched is the one held for the full guard time.
- R9: Reset and `pwr_down` both clear the timers and the sequencer. Each drops `digit_valid` and zeroes the latch on the next cycle. While `pwr_down` stays high, nothing is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_down | input | 1 | Standby: holds timers, sequencer and latch cleared |
| pair_seen | input | 1 | Early "valid pair present" flag from the detector |
| pair_code | input | 4 | Candidate digit code from the detector |
| inhibit_abcd | input | 1 | Ignore letter codes 13, 14, 15, 0 when high |
| guard_present | input | GUARD_W | Present guard time in ticks |
| guard_absent | input | GUARD_W | Absent guard time in ticks |
| out_en | input | 1 | Output enable for the code bus |
| bus_drive | output | 1 | 1 when the code bus is driven |
| bus_code | output | 4 | Latched code, 0 when not driven |
| digit_valid | output | 1 | Delayed steering flag: a digit has been registered |

## Verification
On every cycle, the assertions check several ordering rules. The latch stays frozen while `digit_valid` is high. A rising `digit_valid` follows a stable latch. A falling `digit_valid` follows a low present flag, reset or power-down. A present flag inside the registered state keeps the block registered. An inhibited letter is never written, and power-down clears state on the next cycle. Tick-based guard lengths, code restarts during the present guard, bridged gaps with a changed code, the exact settle delay and independent guard choices depend on stimulus history. The bench's directed and random scenarios are the only way to show those.

// File: rtl/dtmf_steer_pkg.sv
package dtmf_steer_pkg;

    localparam int CODE_W = 4;

    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic [1:0] {
        ST_IDLE          = 2'd0,
        ST_PRESENT_WAIT  = 2'd1,
        ST_REGISTERED    = 2'd2
    } steer_state_e;

    typedef struct packed {
        logic  drive;
        code_t data;
    } code_bus_t;

    // Letter digits A, B, C, D carry codes 13, 14, 15 and 0.
    function automatic logic is_letter(input code_t c);
        return (c == code_t'(13)) || (c == code_t'(14)) ||
               (c == code_t'(15)) || (c == code_t'(0));
    endfunction

endpackage

// File: rtl/dtmf_tick_gen.sv
module dtmf_tick_gen #(
    parameter int unsigned TICK_DIV = 50000
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    output logic tick
);
    localparam int unsigned CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || hold)      cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST) && !hold;

    // Ticks are spaced by the divider, never back to back (TICK_DIV >= 2).
    p_tick_gap_r1: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/dtmf_guard_timer.sv
module dtmf_guard_timer #(
    parameter int GW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          tick,
    input  logic [GW-1:0] limit,
    output logic          elapsed
);
    logic [GW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear)             cnt <= '0;
        else if (tick && cnt != '1)   cnt <= cnt + 1'b1;
    end

    // A timer held in restart never reports expiry, even with a zero limit.
    assign elapsed = !clear && (cnt >= limit);

endmodule

// File: rtl/dtmf_code_latch.sv
module dtmf_code_latch
    import dtmf_steer_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      clr,
    input  logic      wr,
    input  code_t     din,
    input  logic      oe,
    output code_bus_t bus,
    output code_t     held
);
    always_ff @(posedge clk) begin
        if (rst || clr) held <= '0;
        else if (wr)    held <= din;
    end

    always_comb begin
        bus.drive = oe;
        bus.data  = oe ? held : '0;
    end

endmodule

// File: rtl/dtmf_steer.sv
module dtmf_steer
    import dtmf_steer_pkg::*;
#(
    parameter int          GUARD_W  = 8,
    parameter int unsigned TICK_DIV = 50000,
    parameter int unsigned SETTLE   = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pwr_down,
    input  logic               pair_seen,
    input  logic [3:0]         pair_code,
    input  logic               inhibit_abcd,
    input  logic [GUARD_W-1:0] guard_present,
    input  logic [GUARD_W-1:0] guard_absent,
    input  logic               out_en,
    output logic               bus_drive,
    output logic [3:0]         bus_code,
    output logic               digit_valid
);
    localparam int unsigned SW = $clog2(SETTLE + 2);
    localparam logic [SW-1:0] SETTLE_V = SW'(SETTLE);

    steer_state_e state, nxt;
    code_t        hold_code;
    code_t        latched;
    code_bus_t    bus;
    logic [SW-1:0] settle_cnt;
    logic         tick;
    logic         eff_seen, code_change;
    logic         pres_clear, abs_clear, pres_elapsed, abs_elapsed;
    logic         wr_en, take_code;

    // A letter under inhibit is treated exactly like no pair at all.
    assign eff_seen    = pair_seen && !(inhibit_abcd && is_letter(pair_code));
    assign code_change = (state == ST_PRESENT_WAIT) && eff_seen && (pair_code != hold_code);
    assign pres_clear  = (state != ST_PRESENT_WAIT) || !eff_seen || code_change || pwr_down;
    assign abs_clear   = (state != ST_REGISTERED) || eff_seen || pwr_down;

    dtmf_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst(rst), .hold(pwr_down), .tick(tick)
    );

    dtmf_guard_timer #(.GW(GUARD_W)) u_present (
        .clk(clk), .rst(rst), .clear(pres_clear), .tick(tick),
        .limit(guard_present), .elapsed(pres_elapsed)
    );

    dtmf_guard_timer #(.GW(GUARD_W)) u_absent (
        .clk(clk), .rst(rst), .clear(abs_clear), .tick(tick),
        .limit(guard_absent), .elapsed(abs_elapsed)
    );

    always_comb begin
        nxt       = state;
        wr_en     = 1'b0;
        take_code = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (eff_seen) begin
                    nxt       = ST_PRESENT_WAIT;
                    take_code = 1'b1;
                end
            end
            ST_PRESENT_WAIT: begin
                if (!eff_seen)          nxt = ST_IDLE;
                else if (code_change)   take_code = 1'b1;
                else if (pres_elapsed) begin
                    nxt   = ST_REGISTERED;
                    wr_en = 1'b1;
                end
            end
            ST_REGISTERED: begin
                if (abs_elapsed) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || pwr_down) begin
            state       <= ST_IDLE;
            hold_code   <= '0;
            settle_cnt  <= '0;
            digit_valid <= 1'b0;
        end else begin
            state <= nxt;
            if (take_code) hold_code <= pair_code;
            if (wr_en)
                settle_cnt <= SETTLE_V;
            else if (state == ST_REGISTERED && settle_cnt != '0)
                settle_cnt <= settle_cnt - 1'b1;
            digit_valid <= (state == ST_REGISTERED) && !abs_elapsed && (settle_cnt == '0);
        end
    end

    dtmf_code_latch u_latch (
        .clk(clk), .rst(rst), .clr(pwr_down), .wr(wr_en), .din(hold_code),
        .oe(out_en), .bus(bus), .held(latched)
    );

    assign bus_drive = bus.drive;
    assign bus_code  = bus.data;

    // R2: the latch is frozen while the valid flag is up.
    p_latch_frozen_r2: assert property (@(posedge clk) disable iff (rst)
        (digit_valid && !pwr_down) |=> $stable(latched));

    // R2: the flag rises only in the registered state over a settled latch.
    p_flag_after_latch_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(digit_valid) |-> ($past(state == ST_REGISTERED) && $stable(latched)));

    // R3: the flag falls only after the present flag was low (or on clearing).
    p_fall_on_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(digit_valid) |-> ($past(!eff_seen) || $past(pwr_down) || $past(rst)));

    // R4: a present flag during the registered state keeps the digit alive.
    p_bridge_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_REGISTERED && eff_seen && !pwr_down) |=> (state == ST_REGISTERED));

    // R7: an inhibited letter never reaches the latch.
    p_no_letter_r7: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !(inhibit_abcd && is_letter(hold_code)));

    // R9: power-down clears flag, latch and sequencer on the next cycle.
    p_pd_clear_r9: assert property (@(posedge clk) disable iff (rst)
        pwr_down |=> (!digit_valid && latched == '0 && state == ST_IDLE));

endmodule

// File: tb/dtmf_steer_test.sv
module dtmf_steer_test;
    localparam int DIV = 4;
    localparam int SET = 2;
    localparam int GW  = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pwr_down = 1'b0;
    logic          pair_seen = 1'b0;
    logic [3:0]    pair_code = '0;
    logic          inhibit_abcd = 1'b0;
    logic [GW-1:0] guard_present = 8'd4;
    logic [GW-1:0] guard_absent = 8'd3;
    logic          out_en = 1'b1;
    logic          bus_drive;
    logic [3:0]    bus_code;
    logic          digit_valid;

    int checks = 0;
    int failures = 0;
    int cyc_n = 0;
    logic [3:0] exp_code = '0;

    always #10 clk = ~clk;

    dtmf_steer #(.GUARD_W(GW), .TICK_DIV(DIV), .SETTLE(SET)) uut (
        .clk(clk), .rst(rst), .pwr_down(pwr_down), .pair_seen(pair_seen),
        .pair_code(pair_code), .inhibit_abcd(inhibit_abcd),
        .guard_present(guard_present), .guard_absent(guard_absent),
        .out_en(out_en), .bus_drive(bus_drive), .bus_code(bus_code),
        .digit_valid(digit_valid)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc_n);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic bit accepted(input logic [3:0] c, input logic inh);
        return !(inh && (c == 4'd13 || c == 4'd14 || c == 4'd15 || c == 4'd0));
    endfunction

    function automatic int long_len(input int gp);
        return (gp + 2) * DIV + SET + 4;
    endfunction

    function automatic int short_len(input int gp);
        return (gp - 1) * DIV - 1;
    endfunction

    // Monitor for R2: settle delay between latch update and flag rise.
    logic [3:0] prev_q = '0;
    logic       prev_d = 1'b0;
    logic       prev_oe = 1'b0;
    int         chg_cyc = 0;
    bit         chg_seen = 0;
    always @(negedge clk) begin
        cyc_n++;
        if (rst || pwr_down) chg_seen = 0;
        else begin
            if (out_en && prev_oe && bus_code != prev_q) begin
                chg_cyc  = cyc_n;
                chg_seen = 1;
            end
            if (digit_valid && !prev_d && chg_seen && (cyc_n - chg_cyc) < 20) begin
                check((cyc_n - chg_cyc) == SET + 1, "R2 settle delay", cyc_n - chg_cyc, SET + 1);
                chg_seen = 0;
            end
        end
        prev_q  = bus_code;
        prev_d  = digit_valid;
        prev_oe = out_en;
    end

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        finish_run();
    end

    initial begin
        void'($urandom(32'd24681));
        cyc(3);
        rst = 1'b0;
        cyc(1);
        // R9 / R6: reset state
        check(digit_valid == 1'b0, "R9 reset flag", digit_valid, 0);
        check(bus_code == 4'd0, "R9 reset code", bus_code, 0);
        check(bus_drive == 1'b1, "R6 drive with oe", bus_drive, 1);

        // R1: short burst discarded
        guard_present = 8'd4; guard_absent = 8'd3;
        pair_seen = 1'b1; pair_code = 4'd5;
        cyc(short_len(4));
        pair_seen = 1'b0;
        cyc(5 * DIV);
        check(bus_code == 4'd0, "R1 short burst code", bus_code, 0);
        check(digit_valid == 1'b0, "R1 short burst flag", digit_valid, 0);

        // R1/R2: long tone registers
        pair_seen = 1'b1; pair_code = 4'd7;
        cyc(long_len(4));
        check(bus_code == 4'd7, "R2 latched code", bus_code, 7);
        check(digit_valid == 1'b1, "R2 flag up", digit_valid, 1);
        pair_seen = 1'b0;
        cyc((3 - 1) * DIV - 1);
        check(digit_valid == 1'b1, "R3 flag held before absent guard", digit_valid, 1);
        cyc(3 * DIV);
        check(digit_valid == 1'b0, "R3 flag dropped after pause", digit_valid, 0);
        check(bus_code == 4'd7, "R7 last code held", bus_code, 7);

        // R6: output enable
        out_en = 1'b0;
        cyc(1);
        check(bus_drive == 1'b0, "R6 drive off", bus_drive, 0);
        check(bus_code == 4'd0, "R6 data off", bus_code, 0);
        out_en = 1'b1;
        cyc(1);
        check(bus_code == 4'd7, "R6 data back", bus_code, 7);

        // R4: dropout bridged, new code after a gap ignored
        guard_present = 8'd3; guard_absent = 8'd5;
        pair_seen = 1'b1; pair_code = 4'd2;
        cyc(long_len(3));
        pair_seen = 1'b0;
        cyc((5 - 1) * DIV - 1);
        check(digit_valid == 1'b1, "R4 flag through dropout", digit_valid, 1);
        pair_seen = 1'b1; pair_code = 4'd11;
        cyc(long_len(3) + 4);
        check(bus_code == 4'd2, "R4 no repeat registration", bus_code, 2);
        check(digit_valid == 1'b1, "R4 flag still up", digit_valid, 1);
        pair_seen = 1'b0;
        cyc(7 * DIV);
        check(digit_valid == 1'b0, "R4 pause ends digit", digit_valid, 0);

        // R5: short present, long absent
        guard_present = 8'd2; guard_absent = 8'd8;
        pair_seen = 1'b1; pair_code = 4'd4;
        cyc(long_len(2));
        check(bus_code == 4'd4, "R5 short present accepted", bus_code, 4);
        pair_seen = 1'b0;
        cyc(5 * DIV);
        check(digit_valid == 1'b1, "R5 long absent holds", digit_valid, 1);
        cyc(5 * DIV);
        check(digit_valid == 1'b0, "R5 long absent ends", digit_valid, 0);
        // R5: long present, short absent
        guard_present = 8'd8; guard_absent = 8'd2;
        pair_seen = 1'b1; pair_code = 4'd6;
        cyc(6 * DIV);
        pair_seen = 1'b0;
        cyc(4 * DIV);
        check(bus_code == 4'd4, "R5 long present rejects burst", bus_code, 4);
        pair_seen = 1'b1;
        cyc(10 * DIV + 6);
        pair_seen = 1'b0;
        cyc(4 * DIV);
        check(bus_code == 4'd6, "R5 long present accepts", bus_code, 6);
        check(digit_valid == 1'b0, "R5 short absent ends", digit_valid, 0);

        // R8: code change restarts the present guard
        guard_present = 8'd4; guard_absent = 8'd3;
        pair_seen = 1'b1; pair_code = 4'd5;
        cyc(short_len(4));
        pair_code = 4'd9;
        cyc(long_len(4));
        check(bus_code == 4'd9, "R8 final code latched", bus_code, 9);
        pair_seen = 1'b0;
        cyc(5 * DIV);

        // R7: inhibit letters
        inhibit_abcd = 1'b1;
        pair_seen = 1'b1; pair_code = 4'd13;
        cyc(long_len(4));
        check(digit_valid == 1'b0, "R7 inhibited letter no flag", digit_valid, 0);
        pair_seen = 1'b0;
        cyc(5 * DIV);
        check(bus_code == 4'd9, "R7 inhibited letter keeps code", bus_code, 9);
        pair_seen = 1'b1; pair_code = 4'd3;
        cyc(long_len(4));
        pair_seen = 1'b0;
        cyc(5 * DIV);
        check(bus_code == 4'd3, "R7 digit under inhibit", bus_code, 3);
        inhibit_abcd = 1'b0;
        pair_seen = 1'b1; pair_code = 4'd14;
        cyc(long_len(4));
        pair_seen = 1'b0;
        cyc(5 * DIV);
        check(bus_code == 4'd14, "R7 letter accepted", bus_code, 14);

        // R9: power-down
        pair_seen = 1'b1; pair_code = 4'd8;
        cyc(long_len(4));
        check(digit_valid == 1'b1, "R9 registered before pd", digit_valid, 1);
        pwr_down = 1'b1;
        cyc(1);
        check(digit_valid == 1'b0, "R9 pd flag", digit_valid, 0);
        check(bus_code == 4'd0, "R9 pd code", bus_code, 0);
        pair_code = 4'd10;
        cyc(long_len(4));
        check(bus_code == 4'd0, "R9 no accept in pd", bus_code, 0);
        pair_seen = 1'b0;
        pwr_down = 1'b0;
        cyc(5 * DIV);
        exp_code = 4'd0;

        // Random phase
        for (int it = 0; it < 40; it++) begin
            int gp = 2 + int'($urandom % 5);
            int ga = 2 + int'($urandom % 5);
            logic [3:0] c = 4'($urandom % 16);
            logic inh = 1'($urandom % 2);
            bit is_long = ($urandom % 3) != 0;
            guard_present = GW'(gp);
            guard_absent  = GW'(ga);
            inhibit_abcd  = inh;
            pair_code = c;
            pair_seen = 1'b1;
            if (is_long) begin
                cyc(long_len(gp));
                if (accepted(c, inh)) exp_code = c;
                check(digit_valid == accepted(c, inh), "R1 random flag", digit_valid, accepted(c, inh));
                check(bus_code == exp_code, "R7 random latched", bus_code, exp_code);
            end else begin
                cyc(short_len(gp));
            end
            pair_seen = 1'b0;
            cyc((ga + 2) * DIV);
            check(digit_valid == 1'b0, "R3 random pause", digit_valid, 0);
            check(bus_code == exp_code, "R1 random hold", bus_code, exp_code);
        end

        finish_run();
    end
endmodule